// File: doc/BRIEF.md
# Fixed-Point to Signed Integer Rounder

The block converts a signed fixed-point quantity into a signed 32-bit integer. The quantity arrives as a separate sign bit and an unsigned 64-bit magnitude whose low 7 bits are fraction bits. The most significant magnitude bit is expected to be zero. A 2-bit mode input selects one of four rounding directions. The block produces the rounded two's-complement integer together with two flags:

- **invalid**: the rounded value does not fit in 32 bits. The result is then clamped to the most positive or most negative integer.
- **inexact**: fraction bits were discarded.

The block sits on the integer-conversion path of a floating-point datapath. The unpacking logic upstream has already aligned the magnitude. The flags go to an accumulation register outside the block.

The block has one pipeline stage. A one-cycle strobe on `in_valid` loads sign, magnitude and mode. On the next clock edge the result and flags are registered, and `out_valid` is high for that one cycle. Between strobes the registered outputs keep their last values.

Top module: `fxr_round_int`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. In a cycle with `in_valid` low, `out_result`, `out_invalid` and `out_inexact` keep their previous values.
- R2: With `in_mode` = 0 (nearest, ties to even), the magnitude is rounded to the nearest integer. The fraction is `in_mag[6:0]`. A fraction of exactly 0x40 rounds to the even neighbour.
- R3: With `in_mode` = 3 (toward zero), the fraction bits are discarded. The magnitude `in_mag >> 7` is used unchanged.
- R4: With `in_mode` = 1 (toward minus infinity), a positive input drops its fraction. A negative input with a nonzero fraction has its magnitude increased by one.
- R5: With `in_mode` = 2 (toward plus infinity), a negative input drops its fraction. A positive input with a nonzero fraction has its magnitude increased by one.
- R6: When `in_sign` = 1, the result is the two's complement of the rounded magnitude. A rounded magnitude of zero gives 0, with `out_invalid` low.
- R7: A rounded magnitude above 0x7FFFFFFF with a positive sign sets `out_invalid` and gives 0x7FFFFFFF. A rounded magnitude above 0x80000000 with a negative sign sets `out_invalid` and gives 0x80000000.
- R8: `out_inexact` is high exactly when `in_mag[6:0]` is nonzero and the result is not invalid. The two flags are never high together.
- R9: While reset is held, and after it until the first strobe, `out_valid`, `out_result`, `out_invalid` and `out_inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load strobe for sign, magnitude and mode |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_mag | input | 64 | Unsigned magnitude, 7 fraction bits |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 down, 2 up, 3 toward zero |
| out_valid | output | 1 | Result and flags are new in this cycle |
| out_result | output | 32 | Rounded signed integer |
| out_invalid | output | 1 | Result saturated because of overflow |
| out_inexact | output | 1 | Fraction bits were discarded |

## Verification
Each conversion is a single path from one strobe to one registered result, so every internal fault shows up one cycle after the strobe that exercises it. The possible faults are a wrong increment selection, a missed tie correction, a dropped carry out of the fraction, or a wrong saturation bound. Each one gives a result off by one, a wrong flag, or a clamped value where a valid result was due. The stimulus concentrates on the places where these faults show:

- ties on even and odd integers;
- fractions just above and just below one half;
- both signs in every mode;
- the two extreme integers, each with and without a fraction.

A fault in the strobe register would show as a missing or extra `out_valid`, or as outputs changing in idle cycles. The bench checks this in every cycle.

// File: rtl/fxr_pkg.sv
package fxr_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST_EVEN = 2'd0,
      RM_DOWN         = 2'd1,
      RM_UP           = 2'd2,
      RM_TO_ZERO      = 2'd3
   } round_mode_e;
endpackage

// File: rtl/fxr_incr_sel.sv
module fxr_incr_sel #(
   parameter int FRAC_W = 7
) (
   input  logic              sign,
   input  logic [1:0]        mode,
   output logic [FRAC_W-1:0] incr,
   output logic              nearest
);
   import fxr_pkg::*;

   localparam logic [FRAC_W-1:0] HALF_INC = FRAC_W'(1) << (FRAC_W - 1);
   localparam logic [FRAC_W-1:0] FULL_INC = {FRAC_W{1'b1}};

   round_mode_e rm;
   assign rm = round_mode_e'(mode);

   always_comb begin
      nearest = 1'b0;
      incr    = '0;
      unique case (rm)
         RM_NEAREST_EVEN: begin
            nearest = 1'b1;
            incr    = HALF_INC;
         end
         RM_DOWN:    incr = sign ? FULL_INC : '0;
         RM_UP:      incr = sign ? '0 : FULL_INC;
         RM_TO_ZERO: incr = '0;
         default:    incr = '0;
      endcase
   end
endmodule

// File: rtl/fxr_round_shift.sv
module fxr_round_shift #(
   parameter int IN_W   = 64,
   parameter int FRAC_W = 7,
   localparam int SH_W  = IN_W + 1 - FRAC_W
) (
   input  logic [IN_W-1:0]   mag,
   input  logic [FRAC_W-1:0] incr,
   input  logic              nearest,
   output logic [SH_W-1:0]   rounded,
   output logic              frac_nz
);
   localparam logic [FRAC_W-1:0] HALF_PAT = FRAC_W'(1) << (FRAC_W - 1);

   logic [IN_W:0]     sum;
   logic [FRAC_W-1:0] frac;
   logic [SH_W-1:0]   shifted;
   logic              tie;

   assign frac    = mag[FRAC_W-1:0];
   assign sum     = {1'b0, mag} + {{(IN_W + 1 - FRAC_W){1'b0}}, incr};
   assign shifted = sum[IN_W:FRAC_W];
   assign tie     = nearest && (frac == HALF_PAT);
   assign rounded = shifted & ~{{(SH_W - 1){1'b0}}, tie};
   assign frac_nz = |frac;
endmodule

// File: rtl/fxr_saturate.sv
module fxr_saturate #(
   parameter int SH_W  = 58,
   parameter int OUT_W = 32
) (
   input  logic [SH_W-1:0]  rounded,
   input  logic             sign,
   input  logic             frac_nz,
   output logic [OUT_W-1:0] result,
   output logic             invalid,
   output logic             inexact
);
   localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W - 1){1'b1}}};
   localparam logic [OUT_W-1:0] MAX_NEG = {1'b1, {(OUT_W - 1){1'b0}}};

   logic [OUT_W-1:0] low;
   logic             hi_ovf;
   logic [OUT_W-1:0] signed_val;
   logic             sign_bad;

   generate
      if (SH_W > OUT_W) begin : g_wide
         assign hi_ovf = |rounded[SH_W-1:OUT_W];
         assign low    = rounded[OUT_W-1:0];
      end else if (SH_W == OUT_W) begin : g_equal
         assign hi_ovf = 1'b0;
         assign low    = rounded;
      end else begin : g_narrow
         assign hi_ovf = 1'b0;
         assign low    = {{(OUT_W - SH_W){1'b0}}, rounded};
      end
   endgenerate

   assign signed_val = sign ? (~low + OUT_W'(1)) : low;
   assign sign_bad   = (signed_val != '0) && (signed_val[OUT_W-1] != sign);
   assign invalid    = hi_ovf | sign_bad;
   assign result     = invalid ? (sign ? MAX_NEG : MAX_POS) : signed_val;
   assign inexact    = frac_nz & ~invalid;
endmodule

// File: rtl/fxr_round_int.sv
module fxr_round_int #(
   parameter int IN_W   = 64,
   parameter int FRAC_W = 7,
   parameter int OUT_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sign,
   input  logic [IN_W-1:0]  in_mag,
   input  logic [1:0]       in_mode,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_result,
   output logic             out_invalid,
   output logic             out_inexact
);
   localparam int SH_W = IN_W + 1 - FRAC_W;

   initial begin
      assert (FRAC_W >= 1) else $error("FRAC_W must be at least 1");
      assert (OUT_W >= 2) else $error("OUT_W must be at least 2");
      assert (IN_W > FRAC_W) else $error("IN_W must exceed FRAC_W");
   end

   logic [FRAC_W-1:0] incr;
   logic              nearest;
   logic [SH_W-1:0]   rounded;
   logic              frac_nz;
   logic [OUT_W-1:0]  nxt_result;
   logic              nxt_invalid;
   logic              nxt_inexact;

   fxr_incr_sel #(.FRAC_W(FRAC_W)) u_incr (
      .sign    (in_sign),
      .mode    (in_mode),
      .incr    (incr),
      .nearest (nearest)
   );

   fxr_round_shift #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_shift (
      .mag     (in_mag),
      .incr    (incr),
      .nearest (nearest),
      .rounded (rounded),
      .frac_nz (frac_nz)
   );

   fxr_saturate #(.SH_W(SH_W), .OUT_W(OUT_W)) u_sat (
      .rounded (rounded),
      .sign    (in_sign),
      .frac_nz (frac_nz),
      .result  (nxt_result),
      .invalid (nxt_invalid),
      .inexact (nxt_inexact)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= nxt_result;
            out_invalid <= nxt_invalid;
            out_inexact <= nxt_inexact;
         end
      end
   end
endmodule

// File: rtl/fxr_round_int_chk.sv
module fxr_round_int_chk #(
   parameter int IN_W   = 64,
   parameter int FRAC_W = 7,
   parameter int OUT_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sign,
   input logic [IN_W-1:0]  in_mag,
   input logic [1:0]       in_mode,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_result,
   input logic             out_invalid,
   input logic             out_inexact
);
   localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W - 1){1'b1}}};
   localparam logic [OUT_W-1:0] MAX_NEG = {1'b1, {(OUT_W - 1){1'b0}}};

   AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1
   AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result) && $stable(out_invalid) && $stable(out_inexact)); // R1
   AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid ##1 out_invalid |-> out_result == ($past(in_sign) ? MAX_NEG : MAX_POS)); // R7
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact)); // R8
   AST_EXACT_NO_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_mag[FRAC_W-1:0] == '0) |=> !out_inexact); // R8
   AST_SIGN_OF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_sign |=> !out_result[OUT_W-1]); // R6
endmodule

bind fxr_round_int fxr_round_int_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_sign     (in_sign),
   .in_mag      (in_mag),
   .in_mode     (in_mode),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/fxr_round_int_test.sv
module fxr_round_int_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [63:0] in_mag = '0;
   logic [1:0]  in_mode = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_invalid;
   logic        out_inexact;

   typedef struct {
      logic [31:0] res;
      logic        inv;
      logic        inx;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   run_done = 0;

   always #10 clk = ~clk;

   fxr_round_int uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_mag(in_mag), .in_mode(in_mode), .out_valid(out_valid),
      .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   function automatic exp_t model(input logic s, input logic [63:0] m,
                                  input logic [1:0] md, input string req);
      exp_t e;
      logic [63:0] q;
      logic [6:0]  f;
      logic        bump;
      q = m >> 7;
      f = m[6:0];
      case (md)
         2'd0: bump = (f > 7'h40) || (f == 7'h40 && q[0]);
         2'd1: bump = s && (f != 0);
         2'd2: bump = !s && (f != 0);
         default: bump = 1'b0;
      endcase
      q = q + 64'(bump);
      e.req = req;
      if ((!s && q > 64'h7FFFFFFF) || (s && q > 64'h80000000)) begin
         e.inv = 1'b1;
         e.inx = 1'b0;
         e.res = s ? 32'h80000000 : 32'h7FFFFFFF;
      end else begin
         e.inv = 1'b0;
         e.inx = (f != 0);
         e.res = s ? (32'h0 - q[31:0]) : q[31:0];
      end
      return e;
   endfunction

   task automatic drive(input logic s, input logic [63:0] m, input logic [1:0] md,
                        input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_sign  = s;
      in_mag   = m;
      in_mode  = md;
      exp_q.push_back(model(s, m, md, req));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // monitor: samples 5 ns after each rising edge
   initial begin
      logic        iv;
      logic [31:0] last_res;
      logic        last_inv, last_inx;
      exp_t        e;
      last_res = '0; last_inv = 0; last_inx = 0;
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         iv = in_valid;
         #5;
         check(out_valid == iv, "R1", "out_valid", 32'(out_valid), 32'(iv));
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(0, "R1", "unexpected result", out_result, 32'h0);
            end else begin
               e = exp_q.pop_front();
               check(out_result == e.res, e.req, "result", out_result, e.res);
               check(out_invalid == e.inv, e.req, "invalid", 32'(out_invalid), 32'(e.inv));
               check(out_inexact == e.inx, e.req, "inexact", 32'(out_inexact), 32'(e.inx));
            end
         end else begin
            check(out_result == last_res && out_invalid == last_inv && out_inexact == last_inx,
                  "R1", "hold in idle", out_result, last_res);
         end
         last_res = out_result; last_inv = out_invalid; last_inx = out_inexact;
      end
   end

   initial begin
      logic [63:0] lf;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(out_valid == 0 && out_result == 0 && out_invalid == 0 && out_inexact == 0,
            "R9", "reset outputs", out_result, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && out_result == 0, "R9", "after reset", out_result, 32'h0);
      // R2 nearest even
      drive(0, 64'h140, 2'd0, "R2");   // 2.5 -> 2
      drive(0, 64'h1C0, 2'd0, "R2");   // 3.5 -> 4
      drive(0, 64'h141, 2'd0, "R2");   // just above half
      drive(0, 64'h13F, 2'd0, "R2");   // just below half
      drive(1, 64'h140, 2'd0, "R2");   // -2.5 -> -2
      drive(1, 64'h1C0, 2'd0, "R2");   // -3.5 -> -4
      // R3 toward zero
      drive(0, 64'h17F, 2'd3, "R3");
      drive(1, 64'h17F, 2'd3, "R3");
      drive(0, 64'h500, 2'd3, "R3");
      // R4 down
      drive(0, 64'h0A0, 2'd1, "R4");
      drive(1, 64'h0A0, 2'd1, "R4");
      drive(1, 64'h001, 2'd1, "R4");   // -tiny -> -1
      drive(1, 64'h100, 2'd1, "R4");   // exact
      // R5 up
      drive(0, 64'h0A0, 2'd2, "R5");
      drive(1, 64'h0A0, 2'd2, "R5");
      drive(0, 64'h001, 2'd2, "R5");   // +tiny -> 1
      // R6 negation and negative zero
      drive(1, 64'h020, 2'd0, "R6");   // rounds to 0
      drive(1, 64'h040, 2'd2, "R6");   // -0.5 up -> 0
      drive(1, 64'h0, 2'd0, "R6");
      drive(1, 64'h3E80, 2'd3, "R6");  // -125
      // R7 saturation boundaries
      drive(0, 64'h7FFFFFFF << 7, 2'd0, "R7");
      drive(0, (64'h7FFFFFFF << 7) | 64'h40, 2'd0, "R7");
      drive(0, (64'h7FFFFFFF << 7) | 64'h7F, 2'd3, "R7");
      drive(0, (64'h7FFFFFFF << 7) | 64'h01, 2'd2, "R7");
      drive(1, 64'h80000000 << 7, 2'd3, "R7");
      drive(1, (64'h80000000 << 7) | 64'h01, 2'd1, "R7");
      drive(1, (64'h80000000 << 7) | 64'h01, 2'd2, "R7");
      drive(0, 64'h1 << 50, 2'd3, "R7");
      drive(1, 64'h7FFF_FFFF_FFFF_FFFF, 2'd1, "R7");
      // R8 inexact with back-to-back strobes and all modes
      lf = 64'h1234_5678_9ABC_DEF1;
      for (int i = 0; i < 200; i++) begin
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         @(negedge clk);
         in_valid = 1'b1;
         in_sign  = lf[3];
         in_mode  = lf[5:4];
         in_mag   = lf[8] ? {25'h0, lf[38:0]} : {32'h0, lf[31:0]};
         exp_q.push_back(model(in_sign, in_mag, in_mode, "R8"));
         if (lf[10]) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R1", "pending results", 32'(exp_q.size()), 32'h0);
      run_done = 1;
   end

   initial begin
      fork
         wait (run_done);
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=%h expected=%h", 32'h1, 32'h0);
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule